// File: doc/BRIEF.md
# Ping-Pong Tile Transposer for Four-Lane Streams

This block sits inside a streaming datapath and reorders a stream of four-lane bundles one tile at a time. Each tile is 512 bundles long. While a tile is being written into one half of a two-half buffer, the tile before it is read out of the other half in transposed order. In steady state one bundle enters and one bundle leaves on every cycle. Both stream ports use a valid/ready handshake.

A run begins with a start pulse that carries the number of tiles. The block latches that count and walks through count+1 iterations. The first iteration only fills the buffer and the last one only drains it. Input and output advance in lockstep, so backpressure on the output also holds back the input. A one-cycle done pulse marks the end of the run.

Top module: `tile_transposer`

## Requirements
- R1: Lane k of a bundle occupies bits [32k+31:32k]. Within a tile, output bundle j carries in lane k the element of lane (j mod 4) from input bundle 4·(j div 4)+k of the same tile.
- R2: For a run of n tiles, exactly n·512 bundles are emitted. Tiles leave in the order they arrived, and tile t is emitted only after tile t has been fully accepted.
- R3: No output bundle is offered until all 512 bundles of the first tile of a run have been accepted.
- R4: Once n·512 bundles have been accepted, in_ready stays low for the rest of the run while the last tile drains.
- R5: With in_valid and out_ready held high, the done pulse is visible exactly (n+1)·512 clock edges after the edge that samples start. This means one bundle in and one bundle out per cycle, with no stall cycles.
- R6: While one tile is being filled and another drained, an input transfer and an output transfer happen in the same cycles or not at all. The number of accepted bundles never exceeds the number emitted by more than 512.
- R7: done is a single-cycle pulse. It is visible in the cycle right after the final output transfer, and busy is low in that same cycle.
- R8: The tile count is latched when an idle block sees start. A start pulse while busy has no effect on the run.
- R9: A start with a tile count of zero is ignored, and the block stays idle.
- R10: After reset, busy, done, in_ready and out_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a run when the block is idle |
| tiles_i | input | 8 | Number of tiles in the run, sampled with start_i |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| in_valid_i | input | 1 | Input bundle valid |
| in_ready_o | output | 1 | Block accepts an input bundle |
| in_data_i | input | 128 | Input bundle, four 32-bit lanes |
| out_valid_o | output | 1 | Output bundle valid |
| out_ready_i | input | 1 | Downstream accepts an output bundle |
| out_data_o | output | 128 | Transposed output bundle, four 32-bit lanes |

## Verification
The block is exercised with three kinds of pattern:
- A full-rate pattern, with valid and ready held high. It separates a stall-free pipeline from one that drops cycles at tile boundaries, because the done cycle count must match (n+1)·512 exactly.
- Random valid/ready gaps on a two-tile run. These show whether the fill, overlap and drain phases keep both sides in lockstep and keep read and write halves apart.
- Single-tile and zero-count runs, plus a start pulse in the middle of a run. These isolate fill-then-drain without overlap, and show that the count is latched and that spurious starts are ignored.

Every word of every lane carries a value tagged with its tile, bundle and lane. Any wrong bank, half or element shows up as a data mismatch.

// File: rtl/tt_pkg.sv
// Package tt_pkg
// Shared control record passed from the sequencer to the buffer datapath.
// Assumes one write and one read port per bank per cycle.
package tt_pkg;

    // Per-cycle control produced by the sequencer
    typedef struct packed {
        logic step;     // both active sides advance this cycle
        logic wr_en;    // a bundle is stored this cycle
        logic wr_half;  // buffer half being filled
        logic rd_half;  // buffer half being drained
    } tt_ctl_t;

endpackage

// File: rtl/tt_seq.sv
// Module tt_seq
// Iteration and position sequencer for the ping-pong tile transposer.
// Runs count+1 iterations of TILE steps each. The fill side is active in
// iterations 0..n-1 and the drain side in 1..n. Both sides step together.
// Assumes TILE is a power of two and a multiple of the lane count.
module tt_seq #(
    parameter int TILE  = 512,
    parameter int CNT_W = 8,
    localparam int PW   = $clog2(TILE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] tiles_i,
    input  logic             in_valid_i,
    input  logic             out_ready_i,
    output tt_pkg::tt_ctl_t  ctl_o,
    output logic [PW-1:0]    pos_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             in_ready_o,
    output logic             out_valid_o
);
    localparam logic [PW-1:0] LAST_POS = PW'(TILE - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] iter_q;
    logic [CNT_W-1:0] ntiles_q;
    logic [PW-1:0]    pos_q;
    logic             fill_act;
    logic             drain_act;
    logic             step;

    // Decide which sides are active and whether the shared position advances
    always_comb begin
        fill_act    = busy_q && (iter_q < ntiles_q);
        drain_act   = busy_q && (iter_q != '0);
        step        = busy_q && (!fill_act || in_valid_i) && (!drain_act || out_ready_i);
        in_ready_o  = fill_act && (!drain_act || out_ready_i);
        out_valid_o = drain_act && (!fill_act || in_valid_i);
    end

    // Iteration counter, position counter, latched tile count and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            iter_q   <= '0;
            ntiles_q <= '0;
            pos_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i && (tiles_i != '0)) begin
                    busy_q   <= 1'b1;
                    ntiles_q <= tiles_i;
                    iter_q   <= '0;
                    pos_q    <= '0;
                end
            end else if (step) begin
                if (pos_q == LAST_POS) begin
                    pos_q <= '0;
                    if (iter_q == ntiles_q) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // Pack the per-cycle control record for the datapath
    always_comb begin
        ctl_o.step    = step;
        ctl_o.wr_en   = step && fill_act;
        ctl_o.wr_half = iter_q[0];
        ctl_o.rd_half = ~iter_q[0];
    end

    assign pos_o  = pos_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

endmodule

// File: rtl/tt_bank_store.sv
// Module tt_bank_store
// Lane-banked two-half buffer. Input bundle i of a tile is written whole
// into bank (i mod LANES) at row (i div LANES). Output lane k reads bank k
// at the same row and picks one element, so each bank sees at most one
// write and one read per cycle. Assumes LANES is a power of two, >= 2.
module tt_bank_store #(
    parameter int DW    = 32,
    parameter int LANES = 4,
    parameter int DEPTH = 128,
    localparam int LW   = $clog2(LANES),
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = DW * LANES
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic          wr_half_i,
    input  logic [LW-1:0] wr_bank_i,
    input  logic [AW-1:0] wr_row_i,
    input  logic [BW-1:0] wr_data_i,
    input  logic          rd_half_i,
    input  logic [AW-1:0] rd_row_i,
    input  logic [LW-1:0] rd_elem_i,
    output logic [BW-1:0] rd_data_o
);
    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [BW-1:0] mem [2][DEPTH];
        logic [BW-1:0] row_word;

        // Store the whole incoming bundle when this bank is addressed
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_bank_i == LW'(b))) begin
                mem[wr_half_i][wr_row_i] <= wr_data_i;
            end
        end

        // Fetch the selected element of this bank into output lane b
        always_comb begin
            row_word = mem[rd_half_i][rd_row_i];
            rd_data_o[b*DW +: DW] = row_word[rd_elem_i*DW +: DW];
        end
    end

endmodule

// File: rtl/tile_transposer.sv
// Module tile_transposer
// Double-buffered in-stream transposer for four-lane bundles, one tile of
// TILE bundles at a time. Input and output advance in lockstep. The output
// is read combinationally from the banked buffer at the current position.
// Assumes a downstream that can tolerate out_valid depending on in_valid.
module tile_transposer #(
    parameter int DW    = 32,
    parameter int LANES = 4,
    parameter int TILE  = 512,
    parameter int CNT_W = 8,
    localparam int PW   = $clog2(TILE),
    localparam int LW   = $clog2(LANES),
    localparam int DEPTH = TILE / LANES,
    localparam int BW   = DW * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] tiles_i,
    output logic             busy_o,
    output logic             done_o,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [BW-1:0]    in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [BW-1:0]    out_data_o
);
    tt_pkg::tt_ctl_t ctl;
    logic [PW-1:0]   pos;

    tt_seq #(.TILE(TILE), .CNT_W(CNT_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tiles_i     (tiles_i),
        .in_valid_i  (in_valid_i),
        .out_ready_i (out_ready_i),
        .ctl_o       (ctl),
        .pos_o       (pos),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o)
    );

    tt_bank_store #(.DW(DW), .LANES(LANES), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .wr_en_i   (ctl.wr_en),
        .wr_half_i (ctl.wr_half),
        .wr_bank_i (pos[LW-1:0]),
        .wr_row_i  (pos[PW-1:LW]),
        .wr_data_i (in_data_i),
        .rd_half_i (ctl.rd_half),
        .rd_row_i  (pos[PW-1:LW]),
        .rd_elem_i (pos[LW-1:0]),
        .rd_data_o (out_data_o)
    );

endmodule

// File: rtl/tile_transposer_chk.sv
// Module tile_transposer_chk
// Property checker for tile_transposer, bound to every instance. It tracks
// accepted and emitted bundle counts per run to check phase ordering.
module tile_transposer_chk #(
    parameter int TILE  = 512,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] tiles_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_ready_i
);
    logic [31:0]      in_cnt;
    logic [31:0]      out_cnt;
    logic [CNT_W-1:0] n_q;

    // Count transfers on both ports within the current run
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (in_valid_i && in_ready_o)   in_cnt  <= in_cnt + 1;
            if (out_valid_o && out_ready_i) out_cnt <= out_cnt + 1;
        end
    end

    // Remember the tile count of the run that was accepted
    always_ff @(posedge clk) begin
        if (!rst_n) n_q <= '0;
        else if (!busy_o && start_i && (tiles_i != '0)) n_q <= tiles_i;
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!in_ready_o && !out_valid_o && !(done_o && busy_o)));

    p_first_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && in_cnt < 32'(TILE)) |-> !out_valid_o);

    p_drain_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && in_cnt == 32'(n_q) * 32'(TILE)) |-> !in_ready_o);

    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (out_cnt <= in_cnt && (in_cnt - out_cnt) <= 32'(TILE)));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && tiles_i != '0) |=> busy_o);

    p_zero_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && tiles_i == '0) |=> !busy_o);

endmodule

bind tile_transposer tile_transposer_chk #(.TILE(TILE), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tiles_i     (tiles_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i)
);

// File: tb/tile_transposer_tb_top.sv
// Self-checking bench for tile_transposer: full-rate, random-gap, single
// tile, zero-count and mid-run start cases.
module tile_transposer_tb_top;
    localparam int TILE = 512;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [7:0]   tiles_i;
    logic         busy_o, done_o;
    logic         in_valid_i, in_ready_o;
    logic [127:0] in_data_i;
    logic         out_valid_o, out_ready_i;
    logic [127:0] out_data_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    tile_transposer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tiles_i(tiles_i),
        .busy_o(busy_o), .done_o(done_o),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o)
    );

    // Watchdog: a hung run is a failure and still prints the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] gen(int t, int i, int lane);
        return 32'((t * 7919 + i) * 4 + lane) ^ 32'h5A00_0000 ^ 32'(lane << 24);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Run n tiles; mode 1 inserts random gaps; poke issues a start mid-run
    task automatic run(input int n, input bit mode, input bit poke);
        int in_acc = 0, out_acc = 0, done_cnt = 0, done_cyc = -1, last_out = -1;
        for (int c = 0; c < 20000; c++) begin
            int it, ii, ot, oj;
            logic [127:0] exp;
            if (done_cnt > 0 && c > done_cyc + 3) break;
            @(negedge clk);
            start_i = (c == 0) || (poke && c == 300);
            tiles_i = (c == 0) ? 8'(n) : 8'd5;
            it = in_acc / TILE;
            ii = in_acc % TILE;
            in_valid_i = (c > 0) && (it < n) && (mode ? ($urandom % 4 != 0) : 1'b1);
            for (int e = 0; e < 4; e++) in_data_i[e*32 +: 32] = (it < n) ? gen(it, ii, e) : 32'd0;
            out_ready_i = mode ? ($urandom % 3 != 0) : 1'b1;
            #2;
            if (out_valid_o && out_ready_i) begin
                ot = out_acc / TILE;
                oj = out_acc % TILE;
                for (int k = 0; k < 4; k++) exp[k*32 +: 32] = gen(ot, 4 * (oj / 4) + k, oj % 4);
                check(out_data_o == exp, "R1 transposed bundle", out_data_o, exp);
                check(ot < n && in_acc >= (ot + 1) * TILE, "R2 tile order", 128'(in_acc), 128'((ot + 1) * TILE));
                out_acc++;
                last_out = c;
            end
            if (in_acc < TILE) check(!out_valid_o, "R3 no output during first fill", 128'(out_valid_o), 128'd0);
            if (in_acc >= n * TILE) check(!in_ready_o, "R4 input closed in drain", 128'(in_ready_o), 128'd0);
            if (in_acc >= TILE && in_acc < n * TILE)
                check((in_valid_i && in_ready_o) == (out_valid_o && out_ready_i), "R6 lockstep",
                      128'(in_valid_i && in_ready_o), 128'(out_valid_o && out_ready_i));
            if (in_valid_i && in_ready_o) in_acc++;
            @(posedge clk);
            #1;
            if (done_o) begin
                if (done_cnt == 0) done_cyc = c;
                done_cnt++;
                check(!busy_o, "R7 busy low with done", 128'(busy_o), 128'd0);
            end
        end
        start_i = 1'b0;
        in_valid_i = 1'b0;
        check(done_cnt == 1, "R7 single done pulse", 128'(done_cnt), 128'd1);
        check(done_cyc == last_out, "R7 done right after last output", 128'(done_cyc), 128'(last_out));
        check(out_acc == n * TILE, poke ? "R8 mid-run start ignored" : "R2 output count", 128'(out_acc), 128'(n * TILE));
        if (!mode) check(done_cyc == (n + 1) * TILE, "R5 full-rate cycle count", 128'(done_cyc), 128'((n + 1) * TILE));
        check(!busy_o, "R8 idle after run", 128'(busy_o), 128'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start_i = 1'b0; tiles_i = '0;
        in_valid_i = 1'b0; out_ready_i = 1'b0; in_data_i = '0;
        repeat (3) @(posedge clk);
        #1;
        check(!busy_o && !done_o && !in_ready_o && !out_valid_o, "R10 reset state",
              {124'd0, busy_o, done_o, in_ready_o, out_valid_o}, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run(3, 1'b0, 1'b0);   // full rate, overlapping tiles
        run(2, 1'b1, 1'b1);   // random gaps with a spurious start
        run(1, 1'b0, 1'b0);   // fill then drain only
        run(1, 1'b1, 1'b0);   // single tile with gaps

        // Zero tile count is ignored
        @(negedge clk);
        start_i = 1'b1; tiles_i = 8'd0; in_valid_i = 1'b1; out_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!busy_o, "R9 zero count keeps idle", 128'(busy_o), 128'd0);
        check(!in_ready_o && !out_valid_o, "R9 zero count no handshake",
              {126'd0, in_ready_o, out_valid_o}, 128'd0);
        in_valid_i = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule